// File: doc/BRIEF.md
# Partitioned Multi-Bank Array Memory

This block holds a one-dimensional array of words and serves several independent read or write requests in the same clock cycle. The array is cut into a number of smaller banks, each built like a dual-port RAM that can take two accesses per cycle. A compile-time mapping mode decides which bank a logical index lives in. In the consecutive mode each bank holds a contiguous run of indices. In the interleaved mode neighbouring indices land in neighbouring banks. In the flattened mode every element is a register of its own, and any number of ports may use it at once.

Each cycle the requester drives an enable, a write flag, an index and write data on every request port. A front-end decoder turns each index into a bank and an offset, and an arbiter gives each bank's two slots to the lowest-numbered requests. When more than two requests fall in one bank, the block raises `stall`. The requester then holds its inputs and the remaining requests are served in later cycles. `done` marks the cycle in which the last request of a set is granted. Read data comes back one cycle after its grant. An index beyond the array is dropped and raises `err`.

Top module: `pmb_mem`

## Requirements
- R1: In consecutive mode (`MODE`=0), with SPAN = ceil(DEPTH/FACTOR), index i lives in bank i/SPAN at offset i mod SPAN. The final bank is shorter when DEPTH is not a multiple of FACTOR. With defaults (DEPTH 22, FACTOR 4) indices 18..21 share bank 3.
- R2: In interleaved mode (`MODE`=1), index i lives in bank i mod FACTOR at offset i/FACTOR.
- R3: In flattened mode (`MODE`=2), every in-range request is granted in its first cycle and `stall` never rises.
- R4: No bank takes more than two accesses in one cycle. `stall` is high in a cycle exactly when some pending in-range request is left ungranted in that cycle.
- R5: Within a bank, pending requests are granted in ascending port order, two per cycle. While `stall` is high the requester holds every request input stable, and ports already served are not served again.
- R6: `done` is high in a cycle exactly when at least one request is pending and `stall` is low.
- R7: A read granted in cycle t sets its bit of `rd_valid` in cycle t+1, with the word in that port's slice of `rd_data`. A cycle without such a grant leaves the bit low.
- R8: A read returns the contents before the writes of its own grant cycle. A read in any later cycle sees those writes. When two writes to one index are granted in one cycle, the higher port's data is kept.
- R9: A request whose index is DEPTH or more changes no stored word and returns no read data. `err` is high in the first cycle in which such a request is pending, and the request counts as served.
- R10: While `rst` is high and in the cycle after it falls, `stall`, `done`, `err` and `rd_valid` are all low while no request is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_en | input | NPORT | Request enable, one bit per port |
| req_we | input | NPORT | 1 = write, 0 = read, per port |
| req_idx | input | NPORT*IDX_W | Logical element index per port |
| req_wdata | input | NPORT*WIDTH | Write data per port |
| stall | output | 1 | Some pending request could not be granted this cycle |
| done | output | 1 | All pending requests are granted by the end of this cycle |
| err | output | 1 | An out-of-range request is pending in this cycle |
| rd_valid | output | NPORT | Read data valid per port, one cycle after the grant |
| rd_data | output | NPORT*WIDTH | Read data per port |

## Verification
The assertions assume that the requester keeps `req_en`, `req_we` and `req_idx` unchanged in every cycle that follows a stalled one. Serving only the leftover ports, and the claim that some progress is made each stalled cycle, both rest on that. The bench changes its request inputs only after a cycle in which its reference model predicts no stall for any of the three mapping variants. It drives the same request stream into all three so that the same traffic is checked against each mapping. Indices are drawn from a range a little past DEPTH, so that out-of-range requests mix with ordinary ones.

// File: rtl/pmb_pkg.sv
`timescale 1ns/1ps
package pmb_pkg;

    typedef enum logic [1:0] {
        MAP_BLOCK    = 2'd0,
        MAP_CYCLIC   = 2'd1,
        MAP_COMPLETE = 2'd2
    } map_mode_e;

    localparam int SLOTS_PER_BANK = 2;

    typedef struct packed {
        logic take;
        logic slot;
    } grant_t;

    function automatic int span_of(int depth, int factor);
        return (depth + factor - 1) / factor;
    endfunction

    function automatic int width_of(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // number of words stored in bank b
    function automatic int bank_len(map_mode_e mode, int depth, int factor, int b);
        int n;
        if (mode == MAP_CYCLIC) begin
            n = (depth - b + factor - 1) / factor;
        end else begin
            n = depth - b * span_of(depth, factor);
            if (n > span_of(depth, factor)) n = span_of(depth, factor);
        end
        if (n < 1) n = 1;
        return n;
    endfunction

endpackage

// File: rtl/pmb_decode.sv
`timescale 1ns/1ps
module pmb_decode
    import pmb_pkg::*;
#(
    parameter int        DEPTH  = 22,
    parameter int        FACTOR = 4,
    parameter map_mode_e MODE   = MAP_BLOCK,
    parameter int        IW     = 6,
    parameter int        BW     = 2,
    parameter int        OW     = 3
) (
    input  logic [IW-1:0] idx,
    output logic [BW-1:0] bank,
    output logic [OW-1:0] offset,
    output logic          in_range
);
    localparam int SPAN = span_of(DEPTH, FACTOR);

    always_comb begin
        in_range = (int'(idx) < DEPTH);
        bank     = '0;
        offset   = '0;
        if (in_range) begin
            if (MODE == MAP_CYCLIC) begin
                bank   = BW'(int'(idx) % FACTOR);
                offset = OW'(int'(idx) / FACTOR);
            end else if (MODE == MAP_BLOCK) begin
                bank   = BW'(int'(idx) / SPAN);
                offset = OW'(int'(idx) % SPAN);
            end
        end
    end
endmodule

// File: rtl/pmb_arbiter.sv
`timescale 1ns/1ps
module pmb_arbiter
    import pmb_pkg::*;
#(
    parameter int NPORT     = 4,
    parameter int FACTOR    = 4,
    parameter int BW        = 2,
    parameter bit UNLIMITED = 1'b0
) (
    input  logic [NPORT-1:0] want,
    input  logic [BW-1:0]    bank [NPORT],
    output grant_t           gnt  [NPORT]
);
    logic [1:0] used [FACTOR];

    // lowest port first; each bank hands out slot 0 then slot 1
    always_comb begin
        for (int b = 0; b < FACTOR; b++) used[b] = 2'd0;
        for (int p = 0; p < NPORT; p++) begin
            gnt[p] = '{take: 1'b0, slot: 1'b0};
            if (want[p]) begin
                if (UNLIMITED) begin
                    gnt[p].take = 1'b1;
                end else if (used[bank[p]] < 2'(SLOTS_PER_BANK)) begin
                    gnt[p].take    = 1'b1;
                    gnt[p].slot    = used[bank[p]][0];
                    used[bank[p]]  = used[bank[p]] + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/pmb_bank.sv
`timescale 1ns/1ps
module pmb_bank #(
    parameter int LEN = 6,
    parameter int W   = 16,
    parameter int OW  = 3
) (
    input  logic          clk,
    input  logic [1:0]    en,
    input  logic [1:0]    we,
    input  logic [OW-1:0] addr  [2],
    input  logic [W-1:0]  wdata [2],
    output logic [W-1:0]  rdata [2]
);
    logic [W-1:0] store [LEN];

    // reads see the old word; slot 1 (higher port) write lands last
    always_ff @(posedge clk) begin
        for (int s = 0; s < 2; s++) begin
            if (en[s]) begin
                if (we[s]) store[addr[s]] <= wdata[s];
                else       rdata[s]       <= store[addr[s]];
            end
        end
    end
endmodule

// File: rtl/pmb_regs.sv
`timescale 1ns/1ps
module pmb_regs #(
    parameter int NPORT = 4,
    parameter int DEPTH = 22,
    parameter int W     = 16,
    parameter int IW    = 6
) (
    input  logic               clk,
    input  logic [NPORT-1:0]   en,
    input  logic [NPORT-1:0]   we,
    input  logic [NPORT*IW-1:0] idx,
    input  logic [NPORT*W-1:0] wdata,
    output logic [W-1:0]       rdata [NPORT]
);
    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORT; p++) begin
            if (en[p]) begin
                if (we[p]) cells[idx[p*IW +: IW]] <= wdata[p*W +: W];
                else       rdata[p]               <= cells[idx[p*IW +: IW]];
            end
        end
    end
endmodule

// File: rtl/pmb_mem.sv
`timescale 1ns/1ps
module pmb_mem
    import pmb_pkg::*;
#(
    parameter int        NPORT  = 4,
    parameter int        DEPTH  = 22,
    parameter int        WIDTH  = 16,
    parameter int        FACTOR = 4,
    parameter map_mode_e MODE   = MAP_BLOCK,
    parameter int        IDX_W  = $clog2(DEPTH) + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NPORT-1:0]       req_en,
    input  logic [NPORT-1:0]       req_we,
    input  logic [NPORT*IDX_W-1:0] req_idx,
    input  logic [NPORT*WIDTH-1:0] req_wdata,
    output logic                   stall,
    output logic                   done,
    output logic                   err,
    output logic [NPORT-1:0]       rd_valid,
    output logic [NPORT*WIDTH-1:0] rd_data
);
    localparam int  SPAN    = span_of(DEPTH, FACTOR);
    localparam int  BW      = width_of(FACTOR);
    localparam int  OW      = width_of(SPAN);
    localparam bit  FLAT    = (MODE == MAP_COMPLETE);

    logic [NPORT-1:0] served_q;
    logic [NPORT-1:0] pending;
    logic [NPORT-1:0] in_rng;
    logic [NPORT-1:0] oor;
    logic [NPORT-1:0] take;
    logic [BW-1:0]    p_bank [NPORT];
    logic [OW-1:0]    p_off  [NPORT];
    grant_t           gnt    [NPORT];
    logic [WIDTH-1:0] port_rd [NPORT];

    // ---------------- index decode ----------------
    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        pmb_decode #(
            .DEPTH (DEPTH), .FACTOR(FACTOR), .MODE(MODE),
            .IW    (IDX_W), .BW    (BW),     .OW  (OW)
        ) u_dec (
            .idx     (req_idx[p*IDX_W +: IDX_W]),
            .bank    (p_bank[p]),
            .offset  (p_off[p]),
            .in_range(in_rng[p])
        );
    end

    // ---------------- arbitration ----------------
    assign pending = req_en & ~served_q;
    assign oor     = pending & ~in_rng;

    pmb_arbiter #(
        .NPORT(NPORT), .FACTOR(FACTOR), .BW(BW), .UNLIMITED(FLAT)
    ) u_arb (
        .want(pending & in_rng),
        .bank(p_bank),
        .gnt (gnt)
    );

    always_comb begin
        for (int p = 0; p < NPORT; p++) take[p] = gnt[p].take;
    end

    assign stall = |(pending & in_rng & ~take);
    assign done  = (|pending) && !stall;
    assign err   = |oor;

    always_ff @(posedge clk) begin
        if (rst)        served_q <= '0;
        else if (stall) served_q <= served_q | take | oor;
        else            served_q <= '0;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_valid <= '0;
        else     rd_valid <= take & ~req_we;
    end

    // ---------------- storage ----------------
    if (FLAT) begin : g_flat
        pmb_regs #(
            .NPORT(NPORT), .DEPTH(DEPTH), .W(WIDTH), .IW(IDX_W)
        ) u_regs (
            .clk  (clk),
            .en   (take),
            .we   (req_we),
            .idx  (req_idx),
            .wdata(req_wdata),
            .rdata(port_rd)
        );
    end else begin : g_banked
        logic [1:0]       b_en   [FACTOR];
        logic [1:0]       b_we   [FACTOR];
        logic [OW-1:0]    b_addr [FACTOR][2];
        logic [WIDTH-1:0] b_wd   [FACTOR][2];
        logic [WIDTH-1:0] b_rd   [FACTOR][2];
        logic [BW-1:0]    bank_q [NPORT];
        logic             slot_q [NPORT];

        always_comb begin
            for (int b = 0; b < FACTOR; b++) begin
                b_en[b] = 2'b00;
                b_we[b] = 2'b00;
                for (int s = 0; s < 2; s++) begin
                    b_addr[b][s] = '0;
                    b_wd[b][s]   = '0;
                end
            end
            for (int p = 0; p < NPORT; p++) begin
                if (take[p]) begin
                    b_en[p_bank[p]][gnt[p].slot]   = 1'b1;
                    b_we[p_bank[p]][gnt[p].slot]   = req_we[p];
                    b_addr[p_bank[p]][gnt[p].slot] = p_off[p];
                    b_wd[p_bank[p]][gnt[p].slot]   = req_wdata[p*WIDTH +: WIDTH];
                end
            end
        end

        for (genvar b = 0; b < FACTOR; b++) begin : g_bank
            localparam int LEN = bank_len(MODE, DEPTH, FACTOR, b);
            pmb_bank #(.LEN(LEN), .W(WIDTH), .OW(OW)) u_bank (
                .clk  (clk),
                .en   (b_en[b]),
                .we   (b_we[b]),
                .addr (b_addr[b]),
                .wdata(b_wd[b]),
                .rdata(b_rd[b])
            );
        end

        // remember where each granted read went
        always_ff @(posedge clk) begin
            for (int p = 0; p < NPORT; p++) begin
                if (take[p]) begin
                    bank_q[p] <= p_bank[p];
                    slot_q[p] <= gnt[p].slot;
                end
            end
        end

        always_comb begin
            for (int p = 0; p < NPORT; p++) port_rd[p] = b_rd[bank_q[p]][slot_q[p]];
        end
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) rd_data[p*WIDTH +: WIDTH] = port_rd[p];
    end
endmodule

// File: rtl/pmb_mem_chk.sv
`timescale 1ns/1ps
module pmb_mem_chk #(
    parameter int NPORT     = 4,
    parameter int FACTOR    = 4,
    parameter int BW        = 2,
    parameter int IDX_W     = 6,
    parameter bit UNLIMITED = 1'b0
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   stall,
    input logic                   done,
    input logic [NPORT-1:0]       req_en,
    input logic [NPORT-1:0]       req_we,
    input logic [NPORT*IDX_W-1:0] req_idx,
    input logic [NPORT-1:0]       rd_valid,
    input logic [NPORT-1:0]       take,
    input logic [BW-1:0]          p_bank [NPORT]
);
    logic over_limit;

    always_comb begin
        over_limit = 1'b0;
        if (!UNLIMITED) begin
            for (int b = 0; b < FACTOR; b++) begin
                int n;
                n = 0;
                for (int p = 0; p < NPORT; p++)
                    if (take[p] && int'(p_bank[p]) == b) n++;
                if (n > 2) over_limit = 1'b1;
            end
        end
    end

    AST_BANK_PORTS: assert property (@(posedge clk) disable iff (rst)
        !over_limit);                                                   // R4

    AST_STALL_PROGRESS: assert property (@(posedge clk) disable iff (rst)
        stall |-> (|take));                                             // R5

    AST_INPUTS_HELD: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(req_en) && $stable(req_we) && $stable(req_idx))); // R5

    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        done |-> !stall);                                               // R6

    AST_FLAT_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        UNLIMITED |-> !stall);                                          // R3

    for (genvar p = 0; p < NPORT; p++) begin : g_rv
        AST_RVALID_SOURCE: assert property (@(posedge clk) disable iff (rst)
            rd_valid[p] |-> $past(take[p] && !req_we[p]));              // R7
    end
endmodule

bind pmb_mem pmb_mem_chk #(
    .NPORT(NPORT), .FACTOR(FACTOR), .BW(BW), .IDX_W(IDX_W), .UNLIMITED(FLAT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .stall   (stall),
    .done    (done),
    .req_en  (req_en),
    .req_we  (req_we),
    .req_idx (req_idx),
    .rd_valid(rd_valid),
    .take    (take),
    .p_bank  (p_bank)
);

// File: tb/sim_pmb_mem.sv
`timescale 1ns/1ps
module sim_pmb_mem;
    import pmb_pkg::*;

    localparam int NPORT = 4;
    localparam int DEPTH = 22;
    localparam int W     = 16;
    localparam int F     = 4;
    localparam int IW    = $clog2(DEPTH) + 1;
    localparam int SPAN  = (DEPTH + F - 1) / F;
    localparam int ND    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [NPORT-1:0]    req_en = '0;
    logic [NPORT-1:0]    req_we = '0;
    logic [NPORT*IW-1:0] req_idx = '0;
    logic [NPORT*W-1:0]  req_wdata = '0;

    logic             stall_o [ND];
    logic             done_o  [ND];
    logic             err_o   [ND];
    logic [NPORT-1:0] rv_o    [ND];
    logic [NPORT*W-1:0] rd_o  [ND];

    pmb_mem #(.NPORT(NPORT), .DEPTH(DEPTH), .WIDTH(W), .FACTOR(F), .MODE(MAP_BLOCK)) u0 (
        .clk(clk), .rst(rst), .req_en(req_en), .req_we(req_we), .req_idx(req_idx),
        .req_wdata(req_wdata), .stall(stall_o[0]), .done(done_o[0]), .err(err_o[0]),
        .rd_valid(rv_o[0]), .rd_data(rd_o[0]));
    pmb_mem #(.NPORT(NPORT), .DEPTH(DEPTH), .WIDTH(W), .FACTOR(F), .MODE(MAP_CYCLIC)) u1 (
        .clk(clk), .rst(rst), .req_en(req_en), .req_we(req_we), .req_idx(req_idx),
        .req_wdata(req_wdata), .stall(stall_o[1]), .done(done_o[1]), .err(err_o[1]),
        .rd_valid(rv_o[1]), .rd_data(rd_o[1]));
    pmb_mem #(.NPORT(NPORT), .DEPTH(DEPTH), .WIDTH(W), .FACTOR(F), .MODE(MAP_COMPLETE)) u2 (
        .clk(clk), .rst(rst), .req_en(req_en), .req_we(req_we), .req_idx(req_idx),
        .req_wdata(req_wdata), .stall(stall_o[2]), .done(done_o[2]), .err(err_o[2]),
        .rd_valid(rv_o[2]), .rd_data(rd_o[2]));

    // ---------------- reference model ----------------
    int          mem_m    [ND][DEPTH];
    bit [NPORT-1:0] served_m [ND];
    bit [NPORT-1:0] take_m   [ND];
    bit [NPORT-1:0] oor_m    [ND];
    bit [NPORT-1:0] rv_m     [ND];
    int          rd_m     [ND][NPORT];
    bit          stall_m  [ND];
    bit          done_m   [ND];
    bit          err_m    [ND];

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R10 reset";

    function automatic int idx_of(int p);
        return int'(req_idx[p*IW +: IW]);
    endfunction

    function automatic int bank_model(int d, int i);
        if (d == 0) return i / SPAN;   // R1
        return i % F;                  // R2
    endfunction

    task automatic evaluate();
        for (int d = 0; d < ND; d++) begin
            int cnt [F];
            bit [NPORT-1:0] pend;
            for (int b = 0; b < F; b++) cnt[b] = 0;
            pend = req_en & ~served_m[d];
            take_m[d] = '0;
            oor_m[d]  = '0;
            for (int p = 0; p < NPORT; p++) begin
                if (pend[p]) begin
                    if (idx_of(p) >= DEPTH) oor_m[d][p] = 1'b1;
                    else if (d == 2) take_m[d][p] = 1'b1;
                    else if (cnt[bank_model(d, idx_of(p))] < 2) begin
                        take_m[d][p] = 1'b1;
                        cnt[bank_model(d, idx_of(p))]++;
                    end
                end
            end
            stall_m[d] = |(pend & ~take_m[d] & ~oor_m[d]);
            done_m[d]  = (|pend) && !stall_m[d];
            err_m[d]   = |oor_m[d];
        end
    endtask

    task automatic advance();
        for (int d = 0; d < ND; d++) begin
            rv_m[d] = take_m[d] & ~req_we;
            for (int p = 0; p < NPORT; p++)
                if (rv_m[d][p]) rd_m[d][p] = mem_m[d][idx_of(p)];
            for (int p = 0; p < NPORT; p++)
                if (take_m[d][p] && req_we[p]) mem_m[d][idx_of(p)] = int'(req_wdata[p*W +: W]);
            served_m[d] = stall_m[d] ? (served_m[d] | take_m[d] | oor_m[d]) : '0;
        end
    endtask

    task automatic chk(bit ok, string what, int d, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s u%0d %s: actual=%0h expected=%0h", cur_tag, d, what, act, exp);
        end
    endtask

    task automatic compare();
        for (int d = 0; d < ND; d++) begin
            chk(stall_o[d] == stall_m[d], "stall R4", d, stall_o[d], stall_m[d]);
            chk(done_o[d] == done_m[d], "done R6", d, done_o[d], done_m[d]);
            chk(err_o[d] == err_m[d], "err R9", d, err_o[d], err_m[d]);
            chk(rv_o[d] == rv_m[d], "rd_valid R7", d, rv_o[d], rv_m[d]);
            for (int p = 0; p < NPORT; p++)
                if (rv_m[d][p])
                    chk(rd_o[d][p*W +: W] == W'(rd_m[d][p]), "rd_data R8", d,
                        rd_o[d][p*W +: W], W'(rd_m[d][p]));
        end
    endtask

    task automatic step();
        #1;
        evaluate();
        compare();
        @(posedge clk);
        advance();
        @(negedge clk);
    endtask

    task automatic set_port(int p, bit e, bit w, int i, int v);
        req_en[p]             = e;
        req_we[p]             = w;
        req_idx[p*IW +: IW]   = IW'(i);
        req_wdata[p*W +: W]   = W'(v);
    endtask

    // hold the request set until no variant is still serving it
    task automatic run_batch();
        bit busy;
        busy = 1'b1;
        while (busy) begin
            step();
            busy = 1'b0;
            for (int d = 0; d < ND; d++) if (served_m[d] != '0) busy = 1'b1;
        end
    endtask

    task automatic idle();
        req_en = '0;
        step();
    endtask

    task automatic reads4(int a, int b, int c, int e);
        set_port(0, 1, 0, a, 0);
        set_port(1, 1, 0, b, 0);
        set_port(2, 1, 0, c, 0);
        set_port(3, 1, 0, e, 0);
        run_batch();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R6 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int d = 0; d < ND; d++) begin
            served_m[d] = '0; rv_m[d] = '0; take_m[d] = '0; oor_m[d] = '0;
            for (int i = 0; i < DEPTH; i++) mem_m[d][i] = 0;
            for (int p = 0; p < NPORT; p++) rd_m[d][p] = 0;
        end
        repeat (3) @(negedge clk);
        // R10: outputs quiet during reset
        #1;
        for (int d = 0; d < ND; d++) begin
            chk(!stall_o[d] && !done_o[d] && !err_o[d], "R10 flags in reset", d,
                {stall_o[d], done_o[d], err_o[d]}, 0);
            chk(rv_o[d] == '0, "R10 rd_valid in reset", d, rv_o[d], 0);
        end
        @(negedge clk);
        rst = 1'b0;
        step();   // R10: first cycle after reset, no request

        // R8: fill every word (also defines the model's contents)
        cur_tag = "R8 fill";
        for (int base = 0; base < DEPTH; base += NPORT) begin
            for (int p = 0; p < NPORT; p++)
                set_port(p, (base + p) < DEPTH, 1, base + p, (base + p) * 97 + 5);
            run_batch();
        end
        idle();

        cur_tag = "R1 consecutive run, bank 0";
        reads4(0, 1, 2, 3);
        cur_tag = "R1 short last bank";
        reads4(18, 19, 20, 21);
        cur_tag = "R2 interleaved stride";
        reads4(0, 4, 8, 12);
        cur_tag = "R3 same index on every port";
        reads4(5, 5, 5, 5);
        cur_tag = "R5 ascending order 0,1,2 then leftover";
        reads4(0, 1, 2, 6);
        cur_tag = "R7 read latency";
        idle();
        idle();

        cur_tag = "R8 same-cycle write order and old read";
        set_port(0, 1, 0, 7, 0);
        set_port(1, 1, 1, 7, 16'h1111);
        set_port(2, 0, 0, 0, 0);
        set_port(3, 1, 1, 7, 16'h3333);
        run_batch();
        cur_tag = "R8 later read sees write";
        reads4(7, 7, 3, 11);

        cur_tag = "R9 out of range ignored";
        set_port(0, 1, 1, 30, 16'hdead);
        set_port(1, 1, 0, 25, 0);
        set_port(2, 1, 0, 3, 0);
        set_port(3, 0, 0, 0, 0);
        run_batch();
        cur_tag = "R9 all ports out of range";
        reads4(22, 23, 40, 63);
        cur_tag = "R6 idle no done";
        idle();

        cur_tag = "R4 random traffic";
        for (int n = 0; n < 600; n++) begin
            for (int p = 0; p < NPORT; p++)
                set_port(p, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                         int'($urandom_range(0, DEPTH + 1)), int'($urandom_range(0, 65535)));
            run_batch();
            if ($urandom_range(0, 7) == 0) idle();
        end
        idle();
        idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule